// File: doc/BRIEF.md
# Write-Masked PHY Configuration Bridge

This block sits between a host register bus and the narrow configuration port of a serial PHY. The host sees two 32-bit words: a control word that it writes and reads, and a status word that it only reads. Each write to the control word carries its own per-bit enable mask in its upper half. Only the low-half bits whose enable bit is set take the new value, so software can change one field without a read-modify-write sequence.

The low half of the control word packs three fields: a configuration write strobe, a configuration address and a configuration data nibble. When software drives the strobe from 0 to 1, the bridge copies the data nibble into a small configuration store at the addressed entry. Software reads the store by writing a wider read address, which can overlap the data field, and then reading the status word. The status word also reports two PHY flags, PLL locked and PLL output pending, which enter the block as plain input levels.

The host side uses a valid/ready handshake. A read returns its data one cycle after the read is accepted.

Top module: `pcfg_bridge`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0x00000000, every configuration store entry is zero, `rsp_valid` is low and `req_ready` is high.
- R2: A write to the control word (`req_sel`=0) updates each bit x of bits 15:0 to `req_wdata[x]` only when `req_wdata[x+16]` is 1. Every other low bit keeps its previous value.
- R3: A read of the control word returns the 16-bit control register in bits 15:0, and bits 31:16 are always zero.
- R4: When an accepted control write changes bit 0 (the strobe) from 0 to 1, the store entry addressed by the post-write bits 6:1 receives the post-write bits 10:7. This happens at the same clock edge that accepts the write.
- R5: No store entry changes while the strobe stays high, even if the address or data bits change. A further latch requires the strobe to go to 0 and then back to 1.
- R6: Status bits 3:0 return the store entry selected by the 10-bit read address in control bits 10:1. Read addresses 64 and above return 0.
- R7: In the status word, bit 9 equals `pll_locked_i` and bit 10 equals `pll_out_pend_i`, both sampled in the cycle the read is accepted. Bits 8:4 and 31:11 are zero.
- R8: A request is accepted when `req_valid` and `req_ready` are both high. A read response appears with `rsp_valid` high exactly one cycle after acceptance. `req_ready` is low during that response cycle. Writes produce no response.
- R9: Reads of either word leave the control register and the configuration store unchanged.
- R10: Writes with `req_sel`=1 (the status word) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = control word, 1 = status word |
| req_wdata | input | 32 | Write data; bits 31:16 are the bit-enable mask |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data |
| pll_locked_i | input | 1 | PHY flag: PLL locked |
| pll_out_pend_i | input | 1 | PHY flag: PLL output enable still pending |

## Verification
A corrupted mask merge or a lost control bit shows up on the next control read, one cycle after that read is accepted. A corrupted store entry stays hidden until software points the read address at it and reads status. For that reason the bench reads back entries often at random addresses, so that a spurious or missing latch is exposed within a few operations. Handshake faults appear at once on `req_ready` and `rsp_valid`, in the cycle after acceptance.

// File: rtl/pcfg_pkg.sv
// Package: shared field positions and word selects for the PHY configuration bridge.
// Assumes a 32-bit host word whose upper half is a bit-enable mask for the lower half.
package pcfg_pkg;
    localparam int unsigned HOST_W     = 32;
    localparam int unsigned HALF_W     = HOST_W / 2;
    localparam int unsigned STRB_BIT   = 0;
    localparam int unsigned ADDR_LSB   = 1;
    localparam int unsigned LOCK_BIT   = 9;
    localparam int unsigned PEND_BIT   = 10;

    typedef enum logic {
        SEL_CTRL   = 1'b0,
        SEL_STATUS = 1'b1
    } word_sel_e;
endpackage

// File: rtl/pcfg_mask_reg.sv
// Module: masked control register. Holds the low half of the control word.
// Each load replaces only the bits whose enable bit is set, and exposes the
// next value so that neighbours can act on the same edge.
// Assumes the enable mask and the data arrive together in one word.
module pcfg_mask_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] wr_bits,
    input  logic [W-1:0] wr_en,
    output logic [W-1:0] q,
    output logic [W-1:0] nxt
);
    // Merge the enabled new bits with the held bits.
    always_comb begin
        nxt = q;
        if (load) begin
            nxt = (q & ~wr_en) | (wr_bits & wr_en);
        end
    end

    // Register the merged value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/pcfg_strobe_edge.sv
// Module: detects a 0->1 transition of the configuration strobe bit caused by
// a control write. Assumes the strobe only changes when the register loads.
module pcfg_strobe_edge (
    input  logic load,
    input  logic strb_now,
    input  logic strb_next,
    output logic rise
);
    // Rise when the written value sets a strobe that was clear.
    always_comb begin
        rise = load & strb_next & ~strb_now;
    end
endmodule

// File: rtl/pcfg_store.sv
// Module: PHY-side configuration store. Holds DEPTH entries of DATA_W bits
// with a synchronous write port and a combinational read port. The read
// address is wider than the store; out-of-range addresses read as zero.
// Assumes reset clears every entry.
module pcfg_store #(
    parameter int unsigned ADDR_W    = 6,
    parameter int unsigned DATA_W    = 4,
    parameter int unsigned RD_ADDR_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    waddr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [RD_ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0]    rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              r_in_range;

    // One register per entry, cleared by reset, loaded on a matching write.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (we && (waddr == ADDR_W'(i))) begin
                mem[i] <= wdata;
            end
        end
    end

    // Range check and read mux.
    if (RD_ADDR_W > ADDR_W) begin : g_wide
        always_comb begin
            r_in_range = (raddr[RD_ADDR_W-1:ADDR_W] == '0);
        end
    end else begin : g_narrow
        always_comb begin
            r_in_range = 1'b1;
        end
    end

    // Select the addressed entry, or zero when the address is out of range.
    always_comb begin
        rdata = r_in_range ? mem[raddr[ADDR_W-1:0]] : '0;
    end
endmodule

// File: rtl/pcfg_host_port.sv
// Module: host-side handshake and read response. Accepts one request when
// valid meets ready, and registers the read data for one response cycle.
// Ready is withheld during that cycle. Assumes single-beat requests.
module pcfg_host_port #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic         req_write,
    input  logic         req_sel,
    input  logic [W-1:0] ctrl_word,
    input  logic [W-1:0] stat_word,
    output logic         ctrl_load,
    output logic         rsp_valid,
    output logic [W-1:0] rsp_data
);
    import pcfg_pkg::*;

    logic accept;
    logic rd_acc;

    // Decode the handshake.
    always_comb begin
        req_ready = ~rsp_valid;
        accept    = req_valid & req_ready;
        rd_acc    = accept & ~req_write;
        ctrl_load = accept & req_write & (req_sel == SEL_CTRL);
    end

    // Register the response flag and data for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_acc;
            if (rd_acc) begin
                rsp_data <= (req_sel == SEL_CTRL) ? ctrl_word : stat_word;
            end
        end
    end
endmodule

// File: rtl/pcfg_bridge.sv
// Module: top of the write-masked PHY configuration bridge. Connects the host
// port, the masked control register, the strobe edge detector and the
// configuration store, and builds the status word from the store read port
// and the two PHY flags. Assumes the PHY flags are already synchronous to clk.
module pcfg_bridge #(
    parameter int unsigned CFG_ADDR_W = 6,
    parameter int unsigned CFG_DATA_W = 4,
    parameter int unsigned RD_ADDR_W  = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic        req_sel,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_data,
    input  logic        pll_locked_i,
    input  logic        pll_out_pend_i
);
    import pcfg_pkg::*;

    localparam int unsigned DATA_LSB = ADDR_LSB + CFG_ADDR_W;

    logic              ctrl_load;
    logic [HALF_W-1:0] ctl_q;
    logic [HALF_W-1:0] ctl_nxt;
    logic              strb_rise;
    logic [CFG_DATA_W-1:0] cfg_rdata;
    logic [HOST_W-1:0] ctrl_word;
    logic [HOST_W-1:0] stat_word;

    pcfg_host_port #(.W(HOST_W)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_sel   (req_sel),
        .ctrl_word (ctrl_word),
        .stat_word (stat_word),
        .ctrl_load (ctrl_load),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    pcfg_mask_reg #(.W(HALF_W)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ctrl_load),
        .wr_bits (req_wdata[HALF_W-1:0]),
        .wr_en   (req_wdata[HOST_W-1:HALF_W]),
        .q       (ctl_q),
        .nxt     (ctl_nxt)
    );

    pcfg_strobe_edge u_edge (
        .load      (ctrl_load),
        .strb_now  (ctl_q[STRB_BIT]),
        .strb_next (ctl_nxt[STRB_BIT]),
        .rise      (strb_rise)
    );

    pcfg_store #(
        .ADDR_W    (CFG_ADDR_W),
        .DATA_W    (CFG_DATA_W),
        .RD_ADDR_W (RD_ADDR_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (strb_rise),
        .waddr (ctl_nxt[ADDR_LSB +: CFG_ADDR_W]),
        .wdata (ctl_nxt[DATA_LSB +: CFG_DATA_W]),
        .raddr (ctl_q[ADDR_LSB +: RD_ADDR_W]),
        .rdata (cfg_rdata)
    );

    // Assemble the readable control and status words.
    always_comb begin
        ctrl_word = {{(HOST_W-HALF_W){1'b0}}, ctl_q};
        stat_word = '0;
        stat_word[CFG_DATA_W-1:0] = cfg_rdata;
        stat_word[LOCK_BIT]       = pll_locked_i;
        stat_word[PEND_BIT]       = pll_out_pend_i;
    end
endmodule

// File: rtl/pcfg_bridge_chk.sv
// Module: property checker for the PHY configuration bridge, bound to the top.
// Uses the top's ports only.
module pcfg_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic        req_sel,
    input logic        rsp_valid,
    input logic [31:0] rsp_data,
    input logic        pll_locked_i,
    input logic        pll_out_pend_i
);
    logic rd_ctl;
    logic rd_st;
    logic rd_any;

    // Classify accepted read requests.
    always_comb begin
        rd_any = req_valid & req_ready & ~req_write;
        rd_ctl = rd_any & ~req_sel;
        rd_st  = rd_any & req_sel;
    end

    a_r8_ready_low_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r8_resp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_any |=> rsp_valid);

    a_r8_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_any |=> !rsp_valid);

    a_r3_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctl |=> (rsp_data[31:16] == 16'h0));

    a_r7_flags_sampled: assert property (@(posedge clk) disable iff (!rst_n)
        rd_st |=> (rsp_data[9] == $past(pll_locked_i)) && (rsp_data[10] == $past(pll_out_pend_i)));

    a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_st |=> (rsp_data[31:11] == 21'h0) && (rsp_data[8:4] == 5'h0));
endmodule

bind pcfg_bridge pcfg_bridge_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_write      (req_write),
    .req_sel        (req_sel),
    .rsp_valid      (rsp_valid),
    .rsp_data       (rsp_data),
    .pll_locked_i   (pll_locked_i),
    .pll_out_pend_i (pll_out_pend_i)
);

// File: tb/sim_pcfg_bridge.sv
// Bench: fixed-seed random traffic mixed with directed cases, checked against
// a reference model kept in bench functions.
module sim_pcfg_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_sel = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        pll_locked_i = 1'b0;
    logic        pll_out_pend_i = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [15:0] m_ctl;
    logic [3:0]  m_store [64];

    always #2.5 clk = ~clk;

    pcfg_bridge u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_write      (req_write),
        .req_sel        (req_sel),
        .req_wdata      (req_wdata),
        .rsp_valid      (rsp_valid),
        .rsp_data       (rsp_data),
        .pll_locked_i   (pll_locked_i),
        .pll_out_pend_i (pll_out_pend_i)
    );

    function automatic logic [15:0] f_merge(logic [15:0] old, logic [31:0] wd);
        return (old & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
    endfunction

    function automatic logic [31:0] f_status(logic [15:0] ctl, logic [3:0] ent, logic lk, logic pd);
        logic [31:0] s;
        s = '0;
        if (ctl[10:7] == 4'h0) s[3:0] = ent;
        s[9]  = lk;
        s[10] = pd;
        return s;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply a write; update the model as the requirements define.
    task automatic wr(input logic sel, input logic [31:0] wd);
        logic [15:0] nx;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_sel = sel; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        if (sel == 1'b0) begin
            nx = f_merge(m_ctl, wd);
            if (nx[0] && !m_ctl[0]) m_store[nx[6:1]] = nx[10:7];
            m_ctl = nx;
        end
    endtask

    task automatic rd(input logic sel, input logic lk, input logic pd, output logic [31:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_sel = sel;
        pll_locked_i = lk; pll_out_pend_i = pd;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid === 1'b1, "R8 rsp_valid one cycle after read", 32'(rsp_valid), 32'h1);
        check(req_ready === 1'b0, "R8 ready low in response cycle", 32'(req_ready), 32'h0);
        d = rsp_data;
    endtask

    task automatic chk_ctl(input string tag);
        logic [31:0] d;
        rd(1'b0, 1'b0, 1'b0, d);
        check(d === {16'h0, m_ctl}, tag, d, {16'h0, m_ctl});
    endtask

    // Point the read address at an entry without moving the strobe, then read it.
    task automatic chk_ent(input logic [9:0] ra, input string tag);
        logic [31:0] d;
        logic [31:0] e;
        wr(1'b0, {16'h07FE, 5'h0, ra, 1'b0});
        rd(1'b1, 1'b1, 1'b0, d);
        e = f_status(m_ctl, m_store[m_ctl[6:1]], 1'b1, 1'b0);
        check(d === e, tag, d, e);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] e;
        int unsigned seed;
        seed = 32'd2024;
        void'($urandom(seed));
        m_ctl = '0;
        for (int i = 0; i < 64; i++) m_store[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 ready/rsp after reset",
              {30'h0, req_ready, rsp_valid}, 32'h2);
        chk_ctl("R1 control word zero after reset");
        chk_ent(10'd5, "R1 store entry zero after reset");
        chk_ent(10'd63, "R1 store last entry zero after reset");

        // R2: masked write only changes enabled bits
        wr(1'b0, 32'hFFFF_A5A4);
        chk_ctl("R2 full-mask write");
        wr(1'b0, 32'h00F0_0F0F);
        chk_ctl("R2 partial mask keeps other bits");
        wr(1'b0, 32'h0000_FFFF);
        chk_ctl("R2 zero mask changes nothing");
        wr(1'b0, 32'hFFFF_0000);
        chk_ctl("R3 upper half reads zero");

        // R4: strobe rise latches data 10:7 at address 6:1
        wr(1'b0, {16'h07FF, 5'h0, 4'h9, 6'd12, 1'b1});
        chk_ent(10'd12, "R4 latch on strobe rise");
        chk_ent(10'd13, "R4 neighbour untouched");

        // R5: held strobe does not latch; needs a low phase
        wr(1'b0, {16'h07FF, 5'h0, 4'h3, 6'd20, 1'b1});
        wr(1'b0, {16'h07FE, 5'h0, 4'h6, 6'd20, 1'b1});
        chk_ent(10'd20, "R5 held strobe no latch");
        wr(1'b0, {16'h0001, 16'h0000});
        wr(1'b0, {16'h07FF, 5'h0, 4'h7, 6'd20, 1'b1});
        chk_ent(10'd20, "R5 relatch after low phase");

        // R6: out-of-range read address returns zero
        wr(1'b0, {16'h0001, 16'h0000});
        wr(1'b0, {16'h07FF, 5'h0, 4'hF, 6'd0, 1'b1});
        chk_ent(10'd0, "R6 entry 0 in range");
        chk_ent(10'd64, "R6 address 64 reads zero");
        chk_ent(10'h3FF, "R6 max address reads zero");

        // R7: PLL flags in status bits 9 and 10
        for (int k = 0; k < 4; k++) begin
            rd(1'b1, k[0], k[1], d);
            e = f_status(m_ctl, m_store[m_ctl[6:1]], k[0], k[1]);
            check(d === e, "R7 status flags", d, e);
        end

        // R10: writes to status do nothing; R9: reads leave state alone
        wr(1'b1, 32'hFFFF_FFFF);
        chk_ctl("R10 status write ignored (control)");
        chk_ent(10'd12, "R10 status write ignored (store)");
        rd(1'b1, 1'b0, 1'b1, d);
        rd(1'b0, 1'b0, 1'b0, d);
        chk_ctl("R9 reads leave control unchanged");
        chk_ent(10'd20, "R9 reads leave store unchanged");

        // Random traffic against the model
        for (int n = 0; n < 800; n++) begin
            int unsigned op;
            logic [31:0] wd;
            logic lk;
            logic pd;
            op = $urandom_range(0, 9);
            wd = $urandom();
            lk = 1'($urandom());
            pd = 1'($urandom());
            if (op < 5) begin
                wr(1'b0, wd);
            end else if (op == 5) begin
                wr(1'b1, wd);
            end else if (op < 9) begin
                rd(1'b1, lk, pd, d);
                e = f_status(m_ctl, m_store[m_ctl[6:1]], lk, pd);
                check(d === e, "R6 random status read", d, e);
            end else begin
                chk_ctl("R2 random control readback");
            end
        end
        for (int a = 0; a < 64; a += 7) chk_ent(10'(a), "R4 random store sweep");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule